// File: doc/BRIEF.md
# Dual-Vector Single-to-Half Precision Narrowing Packer

This block takes two vectors of IEEE binary32 values and narrows every element to IEEE binary16. It packs all results into one destination vector that has the same total width as one source. The first source vector fills the lower half of the destination and the second fills the upper half, each in element order. There is no masking, so every 16-bit slot of the destination is rewritten on every operation.

Rounding follows a two-bit mode input. Two further controls select flush-to-zero of tiny results and default-NaN substitution. Each operation reports four exception flags: invalid, overflow, underflow and inexact. Each flag is the OR over all converted elements of that operation.

The result is registered once. A request presented with `in_valid` high appears on the outputs one clock later, together with `out_valid`, and the outputs hold while no new request arrives. The vector width `VLEN` is a parameter and must be a multiple of 32.

Top module: `fp_narrow_pack`

## Requirements
- R1: Element e of `src_lo` lands in 16-bit slot e of `dst`, and element e of `src_hi` lands in slot NEL+e, with NEL = VLEN/32. Element e of a source occupies bits [32e+31:32e].
- R2: Finite in-range results are rounded according to `rnd_mode`, with 2'b00 = nearest-even, 2'b01 = toward +infinity, 2'b10 = toward -infinity and 2'b11 = toward zero. A rounded result that differs from the input raises inexact.
- R3: If the rounded result exceeds 65504 in magnitude, the slot receives infinity (0x7C00 or 0xFC00) or the largest finite value (0x7BFF or 0xFBFF), whichever the rounding direction selects, and overflow and inexact are raised. A value that rounds down to 65504 raises only inexact.
- R4: Inputs below 2^-14 in magnitude give correctly rounded binary16 subnormals, or zero, or the smallest normal. Underflow is raised only when the input is below 2^-14 and the result is inexact.
- R5: With `ftz` high, any nonzero input below 2^-14 gives a zero of the input's sign and raises underflow, but not inexact.
- R6: Signed zeros and infinities convert exactly and raise no flag.
- R7: A NaN gives a quiet NaN (bit 9 set) that keeps the sign and fraction bits 21:13 of the input. A signalling NaN (fraction bit 22 clear) also raises invalid. With `dnan` high, every NaN gives 0x7E00.
- R8: Each flag output is the OR over all 2·NEL elements of the latest operation. Flags from earlier operations are not kept.
- R9: `out_valid` equals `in_valid` one cycle earlier. While `in_valid` is low, `dst` and the flags keep their values.
- R10: During reset, `out_valid`, `dst` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Convert the present operands on this cycle |
| src_lo | input | VLEN | First source, binary32 elements, goes to the low half |
| src_hi | input | VLEN | Second source, binary32 elements, goes to the high half |
| rnd_mode | input | 2 | Rounding direction (see R2) |
| ftz | input | 1 | Flush tiny results to signed zero |
| dnan | input | 1 | Replace every NaN result with 0x7E00 |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| dst | output | VLEN | Packed binary16 results |
| flg_invalid | output | 1 | Some element was a signalling NaN |
| flg_overflow | output | 1 | Some element overflowed |
| flg_underflow | output | 1 | Some element underflowed or was flushed |
| flg_inexact | output | 1 | Some element was rounded |

## Verification
On every cycle, the bound checker confirms the one-cycle valid lag and the holding of results while idle. It also confirms that overflow always comes with inexact, and that underflow without flushing always comes with inexact. Invalid must be raised exactly when some operand lane carries a signalling NaN. The exact bit patterns cannot be judged by a generic property and are left to the bench's directed scenarios: slot placement, each rounding direction on ties and near-ties, the overflow boundary at 65504/65520, subnormal rounding including the carry into the smallest normal, flush-to-zero and NaN payload handling.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  localparam int unsigned SP_W = 32;
  localparam int unsigned HP_W = 16;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_UP        = 2'b01,
    RM_DOWN      = 2'b10,
    RM_ZERO      = 2'b11
  } rmode_e;

  typedef struct packed {
    logic nv;
    logic of;
    logic uf;
    logic nx;
  } fpn_flags_t;

  localparam fpn_flags_t FLAGS_NONE = '{nv: 1'b0, of: 1'b0, uf: 1'b0, nx: 1'b0};

  localparam logic [14:0] HP_INF_MAG  = 15'h7C00;
  localparam logic [14:0] HP_MAX_MAG  = 15'h7BFF;
  localparam logic [15:0] HP_DEF_NAN  = 16'h7E00;

endpackage

// File: rtl/fpn_rst_sync.sv
module fpn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fpn_lane.sv
module fpn_lane
  import fpn_pkg::*;
(
  input  logic [31:0]  sp_i,
  input  rmode_e       rm_i,
  input  logic         ftz_i,
  input  logic         dnan_i,
  output logic [15:0]  hp_o,
  output fpn_flags_t   flg_o
);

  // Normal binary16 starts at biased binary32 exponent 113 (2^-14).
  localparam logic [7:0] MIN_NORM_EXP = 8'd113;
  localparam logic [5:0] NORM_SHIFT   = 6'd13;
  localparam logic [5:0] MAX_SHIFT    = 6'd26;

  logic        sgn;
  logic [7:0]  exp_f;
  logic [22:0] frac;
  logic [7:0]  eff_exp;
  logic [5:0]  shamt;
  logic [31:0] sig;
  logic [31:0] kept;
  logic [31:0] rem;
  logic [31:0] half_bit;
  logic [31:0] mag;
  logic        rbit;
  logic        sticky;
  logic        lost;
  logic        inc;
  logic        tiny;
  logic        to_inf;

  assign sgn   = sp_i[31];
  assign exp_f = sp_i[30:23];
  assign frac  = sp_i[22:0];

  // Alignment: 13 bits dropped for normals, more for subnormal results.
  always_comb begin
    eff_exp = (exp_f == 8'd0) ? 8'd1 : exp_f;
    sig     = {8'd0, (exp_f != 8'd0), frac};
    if (eff_exp >= MIN_NORM_EXP) begin
      shamt = NORM_SHIFT;
    end else if (eff_exp <= (MIN_NORM_EXP - 8'd13)) begin
      shamt = MAX_SHIFT;
    end else begin
      shamt = NORM_SHIFT + 6'(MIN_NORM_EXP - eff_exp);
    end
    kept     = sig >> shamt;
    rem      = sig & ((32'd1 << shamt) - 32'd1);
    half_bit = 32'd1 << (shamt - 6'd1);
    rbit     = |(rem & half_bit);
    sticky   = |(rem & (half_bit - 32'd1));
    lost     = |rem;
    tiny     = (eff_exp < MIN_NORM_EXP) && !((exp_f == 8'd0) && (frac == 23'd0));
  end

  // Rounding increment and the direction overflow saturates to.
  always_comb begin
    unique case (rm_i)
      RM_NEAR_EVEN: begin inc = rbit & (sticky | kept[0]); to_inf = 1'b1;  end
      RM_UP:        begin inc = lost & ~sgn;               to_inf = ~sgn;  end
      RM_DOWN:      begin inc = lost & sgn;                to_inf = sgn;   end
      default:      begin inc = 1'b0;                      to_inf = 1'b0;  end
    endcase
  end

  // Magnitude assembly: a carry out of the fraction bumps the exponent.
  always_comb begin
    mag = kept + 32'(inc);
    if (eff_exp >= MIN_NORM_EXP) begin
      mag = mag + ((32'(eff_exp) - 32'(MIN_NORM_EXP)) << 10);
    end
  end

  always_comb begin
    flg_o = FLAGS_NONE;
    hp_o  = {sgn, mag[14:0]};
    if (exp_f == 8'hFF) begin
      if (frac == 23'd0) begin
        hp_o = {sgn, HP_INF_MAG};
      end else begin
        flg_o.nv = ~frac[22];
        hp_o     = dnan_i ? HP_DEF_NAN : {sgn, 5'h1F, 1'b1, frac[21:13]};
      end
    end else if (ftz_i && tiny) begin
      hp_o     = {sgn, 15'd0};
      flg_o.uf = 1'b1;
    end else if (mag >= 32'(HP_INF_MAG)) begin
      flg_o.of = 1'b1;
      flg_o.nx = 1'b1;
      hp_o     = {sgn, (to_inf ? HP_INF_MAG : HP_MAX_MAG)};
    end else begin
      flg_o.nx = lost;
      flg_o.uf = tiny & lost;
    end
  end

endmodule

// File: rtl/fpn_flag_or.sv
module fpn_flag_or
  import fpn_pkg::*;
#(
  parameter int LANES = 8
) (
  input  fpn_flags_t flg_i [LANES],
  output fpn_flags_t flg_o
);

  fpn_flags_t acc [LANES+1];

  assign acc[0] = FLAGS_NONE;

  for (genvar g = 0; g < LANES; g++) begin : g_or
    assign acc[g+1] = acc[g] | flg_i[g];
  end

  assign flg_o = acc[LANES];

endmodule

// File: rtl/fp_narrow_pack.sv
module fp_narrow_pack
  import fpn_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VLEN-1:0] src_lo,
  input  logic [VLEN-1:0] src_hi,
  input  logic [1:0]      rnd_mode,
  input  logic            ftz,
  input  logic            dnan,
  output logic            out_valid,
  output logic [VLEN-1:0] dst,
  output logic            flg_invalid,
  output logic            flg_overflow,
  output logic            flg_underflow,
  output logic            flg_inexact
);

  localparam int NEL   = VLEN / SP_W;
  localparam int SLOTS = 2 * NEL;

  logic            rst_int_n;
  rmode_e          rm;
  logic [VLEN-1:0] packed_res;
  fpn_flags_t      lane_flg [SLOTS];
  fpn_flags_t      flg_all;

  logic            vld_q,  vld_d;
  logic [VLEN-1:0] dst_q,  dst_d;
  fpn_flags_t      flg_q,  flg_d;

  fpn_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign rm = rmode_e'(rnd_mode);

  for (genvar g = 0; g < SLOTS; g++) begin : g_lane
    logic [31:0] opnd;
    if (g < NEL) begin : g_from_lo
      assign opnd = src_lo[SP_W*g +: SP_W];
    end else begin : g_from_hi
      assign opnd = src_hi[SP_W*(g-NEL) +: SP_W];
    end
    fpn_lane i_lane (
      .sp_i   (opnd),
      .rm_i   (rm),
      .ftz_i  (ftz),
      .dnan_i (dnan),
      .hp_o   (packed_res[HP_W*g +: HP_W]),
      .flg_o  (lane_flg[g])
    );
  end

  fpn_flag_or #(.LANES(SLOTS)) i_flag_or (
    .flg_i (lane_flg),
    .flg_o (flg_all)
  );

  // Next-state
  always_comb begin
    vld_d = in_valid;
    dst_d = dst_q;
    flg_d = flg_q;
    if (in_valid) begin
      dst_d = packed_res;
      flg_d = flg_all;
    end
  end

  // State
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
      flg_q <= FLAGS_NONE;
    end else begin
      vld_q <= vld_d;
      dst_q <= dst_d;
      flg_q <= flg_d;
    end
  end

  assign out_valid     = vld_q;
  assign dst           = dst_q;
  assign flg_invalid   = flg_q.nv;
  assign flg_overflow  = flg_q.of;
  assign flg_underflow = flg_q.uf;
  assign flg_inexact   = flg_q.nx;

endmodule

// File: rtl/fp_narrow_pack_chk.sv
module fp_narrow_pack_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [VLEN-1:0] src_lo,
  input logic [VLEN-1:0] src_hi,
  input logic            ftz,
  input logic            out_valid,
  input logic [VLEN-1:0] dst,
  input logic            flg_invalid,
  input logic            flg_overflow,
  input logic            flg_underflow,
  input logic            flg_inexact
);

  localparam int NEL = VLEN / 32;

  logic [2*NEL-1:0] snan_v;

  for (genvar g = 0; g < NEL; g++) begin : g_snan
    assign snan_v[g]     = (src_lo[32*g+23 +: 8] == 8'hFF) && (src_lo[32*g +: 22] != 22'd0)
                           && !src_lo[32*g+22];
    assign snan_v[NEL+g] = (src_hi[32*g+23 +: 8] == 8'hFF) && (src_hi[32*g +: 22] != 22'd0)
                           && !src_hi[32*g+22];
  end

  p_valid_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst) && $stable(flg_invalid) && $stable(flg_overflow)
                   && $stable(flg_underflow) && $stable(flg_inexact)));

  p_ovf_inexact_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flg_overflow |-> flg_inexact);

  p_uf_inexact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ftz) |=> (!flg_underflow || flg_inexact));

  p_nv_raised_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (snan_v != '0)) |=> flg_invalid);

  p_nv_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (snan_v == '0)) |=> !flg_invalid);

endmodule

bind fp_narrow_pack fp_narrow_pack_chk #(.VLEN(VLEN)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .src_lo        (src_lo),
  .src_hi        (src_hi),
  .ftz           (ftz),
  .out_valid     (out_valid),
  .dst           (dst),
  .flg_invalid   (flg_invalid),
  .flg_overflow  (flg_overflow),
  .flg_underflow (flg_underflow),
  .flg_inexact   (flg_inexact)
);

// File: tb/test_fp_narrow_pack.sv
module test_fp_narrow_pack;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN       = 128;
  localparam int NEL        = VLEN / 32;

  localparam logic [31:0] ONE = 32'h3F800000;
  localparam logic [15:0] H1  = 16'h3C00;
  localparam logic [1:0]  RNE = 2'b00, RUP = 2'b01, RDN = 2'b10, RZ = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [VLEN-1:0] src_lo, src_hi;
  logic [1:0]      rnd_mode;
  logic            ftz, dnan;
  logic            out_valid;
  logic [VLEN-1:0] dst;
  logic            flg_invalid, flg_overflow, flg_underflow, flg_inexact;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_narrow_pack #(.VLEN(VLEN)) i_fp_narrow_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_lo(src_lo), .src_hi(src_hi), .rnd_mode(rnd_mode),
    .ftz(ftz), .dnan(dnan), .out_valid(out_valid), .dst(dst),
    .flg_invalid(flg_invalid), .flg_overflow(flg_overflow),
    .flg_underflow(flg_underflow), .flg_inexact(flg_inexact)
  );

  function automatic logic [3:0] flags_now();
    return {flg_invalid, flg_overflow, flg_underflow, flg_inexact};
  endfunction

  task automatic check(input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One request; returns at the negedge after the capturing edge.
  task automatic run_op(input logic [VLEN-1:0] lo, input logic [VLEN-1:0] hi,
                        input logic [1:0] rm, input logic fz, input logic dn);
    @(negedge clk);
    src_lo = lo; src_hi = hi; rnd_mode = rm; ftz = fz; dnan = dn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_op(input string tag, input logic [VLEN-1:0] exp_dst, input logic [3:0] exp_flg);
    for (int s = 0; s < 2*NEL; s++) begin
      check($sformatf("%s slot %0d", tag, s), VLEN'(dst[16*s +: 16]), VLEN'(exp_dst[16*s +: 16]));
    end
    check({tag, " flags{nv,of,uf,nx}"}, VLEN'(flags_now()), VLEN'(exp_flg));
  endtask

  task automatic t_reset();
    check("R10 out_valid in reset", VLEN'(out_valid), '0);
    check("R10 dst in reset", dst, '0);
    check("R10 flags in reset", VLEN'(flags_now()), '0);
  endtask

  task automatic t_layout();
    run_op({32'h3FC00000, 32'h3F000000, 32'hC0000000, ONE},
           {32'h477FE000, 32'hFF800000, 32'h7F800000, 32'h80000000}, RNE, 1'b0, 1'b0);
    check("R9 out_valid after request", VLEN'(out_valid), VLEN'(1));
    expect_op("R1/R6 layout exact",
              {16'h7BFF, 16'hFC00, 16'h7C00, 16'h8000, 16'h3E00, 16'h3800, 16'hC000, H1}, 4'b0000);
  endtask

  task automatic t_rounding();
    logic [VLEN-1:0] lo = {32'h3F801008, 32'hBF801000, 32'h3F803000, 32'h3F801000};
    logic [VLEN-1:0] hi = {ONE, ONE, ONE, ONE};
    run_op(lo, hi, RNE, 1'b0, 1'b0);
    expect_op("R2 nearest-even", {H1, H1, H1, H1, 16'h3C01, 16'hBC00, 16'h3C02, 16'h3C00}, 4'b0001);
    run_op(lo, hi, RUP, 1'b0, 1'b0);
    expect_op("R2 toward +inf", {H1, H1, H1, H1, 16'h3C01, 16'hBC00, 16'h3C02, 16'h3C01}, 4'b0001);
    run_op(lo, hi, RDN, 1'b0, 1'b0);
    expect_op("R2 toward -inf", {H1, H1, H1, H1, 16'h3C00, 16'hBC01, 16'h3C01, 16'h3C00}, 4'b0001);
    run_op(lo, hi, RZ, 1'b0, 1'b0);
    expect_op("R2 toward zero", {H1, H1, H1, H1, 16'h3C00, 16'hBC00, 16'h3C01, 16'h3C00}, 4'b0001);
  endtask

  task automatic t_overflow();
    logic [VLEN-1:0] lo = {32'h477FE000, 32'hC7C35000, 32'h47C35000, 32'h477FF000};
    logic [VLEN-1:0] hi = {ONE, ONE, ONE, ONE};
    run_op(lo, hi, RNE, 1'b0, 1'b0);
    expect_op("R3 overflow RNE", {H1, H1, H1, H1, 16'h7BFF, 16'hFC00, 16'h7C00, 16'h7C00}, 4'b0101);
    run_op(lo, hi, RUP, 1'b0, 1'b0);
    expect_op("R3 overflow RUP", {H1, H1, H1, H1, 16'h7BFF, 16'hFBFF, 16'h7C00, 16'h7C00}, 4'b0101);
    run_op(lo, hi, RDN, 1'b0, 1'b0);
    expect_op("R3 overflow RDN", {H1, H1, H1, H1, 16'h7BFF, 16'hFC00, 16'h7BFF, 16'h7BFF}, 4'b0101);
    run_op(lo, hi, RZ, 1'b0, 1'b0);
    expect_op("R3 overflow RZ", {H1, H1, H1, H1, 16'h7BFF, 16'hFBFF, 16'h7BFF, 16'h7BFF}, 4'b0101);
    run_op({ONE, ONE, ONE, 32'h477FF000}, hi, RZ, 1'b0, 1'b0);
    expect_op("R3 round down to max, no overflow", {H1, H1, H1, H1, H1, H1, H1, 16'h7BFF}, 4'b0001);
  endtask

  task automatic t_subnormal();
    logic [VLEN-1:0] lo = {32'h387FE000, 32'h33400000, 32'h33000000, 32'h33800000};
    logic [VLEN-1:0] hi = {32'h38800000, 32'h80000001, 32'h00000001, 32'h38000000};
    run_op(lo, hi, RNE, 1'b0, 1'b0);
    expect_op("R4 subnormal RNE",
              {16'h0400, 16'h8000, 16'h0000, 16'h0200, 16'h0400, 16'h0001, 16'h0000, 16'h0001}, 4'b0011);
    run_op(lo, hi, RUP, 1'b0, 1'b0);
    expect_op("R4 subnormal RUP",
              {16'h0400, 16'h8000, 16'h0001, 16'h0200, 16'h0400, 16'h0001, 16'h0001, 16'h0001}, 4'b0011);
    run_op(lo, hi, RDN, 1'b0, 1'b0);
    expect_op("R4 subnormal RDN",
              {16'h0400, 16'h8001, 16'h0000, 16'h0200, 16'h03FF, 16'h0000, 16'h0000, 16'h0001}, 4'b0011);
    run_op({ONE, ONE, 32'h38000000, 32'h33800000}, {ONE, ONE, ONE, ONE}, RNE, 1'b0, 1'b0);
    expect_op("R4 exact tiny no underflow", {H1, H1, H1, H1, H1, H1, 16'h0200, 16'h0001}, 4'b0000);
  endtask

  task automatic t_flush();
    run_op({32'h38800000, 32'h00000001, 32'hB8000000, 32'h33400000}, {ONE, ONE, ONE, ONE},
           RNE, 1'b1, 1'b0);
    expect_op("R5 flush-to-zero", {H1, H1, H1, H1, 16'h0400, 16'h0000, 16'h8000, 16'h0000}, 4'b0010);
  endtask

  task automatic t_nan();
    logic [VLEN-1:0] lo = {32'hFFC00000, 32'h7FC02000, 32'hFFA00000, 32'h7F800001};
    run_op(lo, {ONE, ONE, ONE, ONE}, RNE, 1'b0, 1'b0);
    expect_op("R7 NaN payload", {H1, H1, H1, H1, 16'hFE00, 16'h7E01, 16'hFF00, 16'h7E00}, 4'b1000);
    run_op(lo, {ONE, ONE, ONE, ONE}, RNE, 1'b0, 1'b1);
    expect_op("R7 default NaN", {H1, H1, H1, H1, 16'h7E00, 16'h7E00, 16'h7E00, 16'h7E00}, 4'b1000);
    run_op({ONE, ONE, 32'hFFC00000, 32'h7FC02000}, {ONE, ONE, ONE, ONE}, RNE, 1'b0, 1'b0);
    expect_op("R7 quiet NaN no invalid", {H1, H1, H1, H1, H1, H1, 16'hFE00, 16'h7E01}, 4'b0000);
  endtask

  task automatic t_flag_merge();
    run_op({ONE, ONE, ONE, 32'h47C35000}, {32'h7F800001, ONE, ONE, ONE}, RNE, 1'b0, 1'b0);
    expect_op("R8 flags merged", {16'h7E00, H1, H1, H1, H1, H1, H1, 16'h7C00}, 4'b1101);
    run_op({ONE, ONE, ONE, ONE}, {ONE, ONE, ONE, ONE}, RNE, 1'b0, 1'b0);
    expect_op("R8 flags not sticky", {H1, H1, H1, H1, H1, H1, H1, H1}, 4'b0000);
  endtask

  task automatic t_hold();
    logic [VLEN-1:0] snap;
    run_op({32'hC0000000, ONE, ONE, ONE}, {ONE, ONE, ONE, 32'h47C35000}, RNE, 1'b0, 1'b0);
    snap = dst;
    src_lo = {4{32'h7F800001}}; src_hi = {4{32'h33400000}};
    @(negedge clk);
    check("R9 out_valid drops", VLEN'(out_valid), '0);
    @(negedge clk);
    check("R9 dst held while idle", dst, snap);
    check("R9 flags held while idle", VLEN'(flags_now()), VLEN'(4'b0101));
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src_lo = '0; src_hi = '0;
    rnd_mode = RNE; ftz = 1'b0; dnan = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_layout();
    t_rounding();
    t_overflow();
    t_subnormal();
    t_flush();
    t_nan();
    t_flag_merge();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule